// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the 12-bit fetch address of a small controller whose program store is cut into four pages of 1024 words. Each clock edge applies at most one address command. The commands are stepping to the next word, jumping or calling to an immediate target, loading the address from the accumulator, adding the accumulator to it, a table-read add, entering the interrupt handler, and returning. The two page bits come from a separate 2-bit page-select input on the commands that leave the current page. Bits 9..8 are either forced to zero or kept, depending on the command.

Calls and interrupt entry push a return address onto an eight-deep hardware ring. Every return command pops it. On interrupt entry the block also copies the accumulator, the status byte and the page byte into shadow registers. A return-from-interrupt raises a one-cycle restore strobe so that the surrounding core can write those three bytes back. Command strobes come from the instruction decoder, which is outside this block.

Top module: `pgpc_top`

## Requirements
- R1: While reset is low, and after it rises with no command, the address reads 0x000, the restore strobe is low and all three shadow bytes read 0x00. A return issued before any push loads 0x000.
- R2: A step command sets the address to the old address plus one, modulo 4096. The step carries across page boundaries, and 0xFFF steps to 0x000.
- R3: A jump sets the address to {page_sel[1:0], imm[9:0]}.
- R4: A call sets the address to {page_sel, imm}. It pushes the old address plus one, modulo 4096, as the return address.
- R5: A load-from-accumulator sets bits 11..10 to page_sel, bits 9..8 to 00 and bits 7..0 to the accumulator.
- R6: An add-accumulator sets bits 11..10 to page_sel and bits 9..8 to 00. Bits 7..0 become the old bits 7..0 plus the accumulator, modulo 256.
- R7: A table-read add keeps bits 11..8. Bits 7..0 become the old bits 7..0 plus the accumulator, modulo 256, and any carry out of bit 7 is dropped.
- R8: Interrupt entry sets the address to 0x008 and pushes the old, unchanged address. It captures the accumulator, status and page-byte inputs into the shadow outputs.
- R9: A plain return, and a return-from-interrupt, each load the address with the most recently pushed return address that has not yet been popped (last in, first out).
- R10: The ring holds eight entries. A ninth push overwrites the oldest entry. After nine pushes P1..P9, nine pops return P9, P8, ..., P2 and then P9 again.
- R11: In the cycle after a return-from-interrupt edge, the restore strobe is high. The strobe is low in every other cycle. The shadow bytes are unchanged until the next interrupt entry.
- R12: When several strobes are high together, only one acts, with priority from highest to lowest: interrupt, return-from-interrupt, return, call, jump, load, add, table add, step. With no strobe high, the address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_step | input | 1 | Advance to the next word |
| cmd_jmp | input | 1 | Jump to the immediate target |
| cmd_call | input | 1 | Call the immediate target and push the return address |
| cmd_lda | input | 1 | Load address low byte from the accumulator |
| cmd_adda | input | 1 | Add the accumulator, clear bits 9..8, take the page from page_sel |
| cmd_tbl | input | 1 | Table-read add that keeps bits 11..8 |
| cmd_irq | input | 1 | Interrupt entry |
| cmd_ret | input | 1 | Return (plain or with literal) |
| cmd_reti | input | 1 | Return from interrupt |
| imm | input | 10 | Jump or call target within the page |
| acc_in | input | 8 | Accumulator value |
| page_sel | input | 2 | Page-select bits for address bits 11..10 |
| stat_in | input | 8 | Status byte to be saved on interrupt |
| pgbyte_in | input | 8 | Page byte to be saved on interrupt |
| pc_out | output | 12 | Current program address |
| ctx_acc | output | 8 | Saved accumulator |
| ctx_stat | output | 8 | Saved status byte |
| ctx_pgbyte | output | 8 | Saved page byte |
| ctx_restore | output | 1 | One-cycle strobe after a return-from-interrupt |

## Verification
The bench targets the step from 0xFFF to 0x000, table adds whose low byte carries out while bits 9..8 are nonzero, and add or load commands issued from an address whose bits 9..8 are set. A design that let the carry ripple, or kept the wrong middle bits, would land on the wrong page. It pushes nine times and pops nine times, and pops on an empty ring after reset. A design with a saturating or off-by-one pointer would return the wrong addresses at the seam. Colliding strobes expose a priority encoder in the wrong order. Interrupt and return-from-interrupt pairs catch a shadow that is lost, or a restore strobe that is late or held high for more than one cycle.

// File: rtl/pgpc_pkg.sv
// Package: shared command encoding for the paged program counter.
// Assumes exactly one operation is chosen per cycle by the arbiter.
package pgpc_pkg;

    typedef enum logic [3:0] {
        OP_HOLD = 4'd0,
        OP_STEP = 4'd1,
        OP_JMP  = 4'd2,
        OP_CALL = 4'd3,
        OP_LDA  = 4'd4,
        OP_ADDA = 4'd5,
        OP_TBL  = 4'd6,
        OP_IRQ  = 4'd7,
        OP_RET  = 4'd8,
        OP_RETI = 4'd9
    } pc_op_e;

endpackage

// File: rtl/pgpc_cmd_arb.sv
// Module: pgpc_cmd_arb
// Reduces the command strobes to a single operation by fixed priority:
// interrupt, return-from-interrupt, return, call, jump, load, add, table add, step.
// Assumes the strobes are sampled in the same cycle as their operands.
module pgpc_cmd_arb
    import pgpc_pkg::*;
(
    input  logic   cmd_step,
    input  logic   cmd_jmp,
    input  logic   cmd_call,
    input  logic   cmd_lda,
    input  logic   cmd_adda,
    input  logic   cmd_tbl,
    input  logic   cmd_irq,
    input  logic   cmd_ret,
    input  logic   cmd_reti,
    output pc_op_e op
);

    // Priority chain: the first high strobe in order wins.
    always_comb begin
        if (cmd_irq)       op = OP_IRQ;
        else if (cmd_reti) op = OP_RETI;
        else if (cmd_ret)  op = OP_RET;
        else if (cmd_call) op = OP_CALL;
        else if (cmd_jmp)  op = OP_JMP;
        else if (cmd_lda)  op = OP_LDA;
        else if (cmd_adda) op = OP_ADDA;
        else if (cmd_tbl)  op = OP_TBL;
        else if (cmd_step) op = OP_STEP;
        else               op = OP_HOLD;
    end

endmodule

// File: rtl/pgpc_next_addr.sv
// Module: pgpc_next_addr
// Combinational next-address former. It assembles the page bits, the middle
// bits and the low byte for every operation, and it decides the stack push
// and pop. Assumes PC_W = PAGE_W + OFS_W and OFS_W > DATA_W.
module pgpc_next_addr
    import pgpc_pkg::*;
#(
    parameter int PC_W    = 12,
    parameter int PAGE_W  = 2,
    parameter int OFS_W   = 10,
    parameter int DATA_W  = 8,
    parameter int IRQ_VEC = 8
) (
    input  pc_op_e              op,
    input  logic [PC_W-1:0]     pc,
    input  logic [PC_W-1:0]     stk_top,
    input  logic [PAGE_W-1:0]   page_sel,
    input  logic [OFS_W-1:0]    imm,
    input  logic [DATA_W-1:0]   acc,
    output logic [PC_W-1:0]     pc_nxt,
    output logic                push,
    output logic                pop,
    output logic [PC_W-1:0]     push_val
);

    localparam int MID_W = OFS_W - DATA_W;

    logic [PC_W-1:0]   pc_inc;
    logic [DATA_W-1:0] low_sum;

    // Shared arithmetic: sequential successor and low-byte relative sum.
    always_comb begin
        pc_inc  = pc + PC_W'(1);
        low_sum = pc[DATA_W-1:0] + acc;
    end

    // Address selection per operation.
    always_comb begin
        case (op)
            OP_STEP:         pc_nxt = pc_inc;
            OP_JMP, OP_CALL: pc_nxt = {page_sel, imm};
            OP_LDA:          pc_nxt = {page_sel, {MID_W{1'b0}}, acc};
            OP_ADDA:         pc_nxt = {page_sel, {MID_W{1'b0}}, low_sum};
            OP_TBL:          pc_nxt = {pc[PC_W-1:DATA_W], low_sum};
            OP_IRQ:          pc_nxt = PC_W'(IRQ_VEC);
            OP_RET, OP_RETI: pc_nxt = stk_top;
            default:         pc_nxt = pc;
        endcase
    end

    // Stack control: calls save the successor, interrupts the preempted address.
    always_comb begin
        push     = (op == OP_CALL) || (op == OP_IRQ);
        pop      = (op == OP_RET)  || (op == OP_RETI);
        push_val = (op == OP_CALL) ? pc_inc : pc;
    end

endmodule

// File: rtl/pgpc_ret_stack.sv
// Module: pgpc_ret_stack
// Ring-style return stack of DEPTH entries. A push past DEPTH overwrites the
// oldest entry. A pop past the bottom keeps walking the ring, with no flag.
// Assumes DEPTH is a power of two and push and pop are never high together.
module pgpc_ret_stack #(
    parameter int W     = 12,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_idx;
    logic [W-1:0]     ent [DEPTH];

    // Write pointer: advances on push, retreats on pop, wraps freely.
    always_ff @(posedge clk) begin
        if (!rst_n)    wr_ptr <= '0;
        else if (push) wr_ptr <= wr_ptr + PTR_W'(1);
        else if (pop)  wr_ptr <= wr_ptr - PTR_W'(1);
    end

    // One register per slot, written when the pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)                            q <= '0;
            else if (push && wr_ptr == PTR_W'(g))  q <= wdata;
        end
        assign ent[g] = q;
    end

    // Top of stack is the slot just below the write pointer.
    always_comb begin
        rd_idx = wr_ptr - PTR_W'(1);
        top    = ent[rd_idx];
    end

endmodule

// File: rtl/pgpc_ctx_shadow.sv
// Module: pgpc_ctx_shadow
// Single-level interrupt context shadow. It captures the accumulator, status
// and page byte on interrupt entry, and it pulses a restore strobe one cycle
// after a return-from-interrupt. A nested entry overwrites the saved bytes.
module pgpc_ctx_shadow #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save,
    input  logic              restore,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] stat_in,
    input  logic [DATA_W-1:0] pgbyte_in,
    output logic [DATA_W-1:0] acc_q,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] pgbyte_q,
    output logic              restore_q
);

    // Shadow capture on interrupt entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            stat_q   <= '0;
            pgbyte_q <= '0;
        end else if (save) begin
            acc_q    <= acc_in;
            stat_q   <= stat_in;
            pgbyte_q <= pgbyte_in;
        end
    end

    // Registered one-cycle restore strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) restore_q <= 1'b0;
        else        restore_q <= restore;
    end

endmodule

// File: rtl/pgpc_top.sv
// Module: pgpc_top
// Paged program counter. It arbitrates the command strobes, forms the next
// address, keeps the return ring and the interrupt context shadow.
// Assumes the decoder raises strobes for one cycle per instruction.
module pgpc_top
    import pgpc_pkg::*;
#(
    parameter int PC_W      = 12,
    parameter int PAGE_W    = 2,
    parameter int DATA_W    = 8,
    parameter int STK_DEPTH = 8,
    parameter int IRQ_VEC   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_step,
    input  logic              cmd_jmp,
    input  logic              cmd_call,
    input  logic              cmd_lda,
    input  logic              cmd_adda,
    input  logic              cmd_tbl,
    input  logic              cmd_irq,
    input  logic              cmd_ret,
    input  logic              cmd_reti,
    input  logic [9:0]        imm,
    input  logic [7:0]        acc_in,
    input  logic [1:0]        page_sel,
    input  logic [7:0]        stat_in,
    input  logic [7:0]        pgbyte_in,
    output logic [11:0]       pc_out,
    output logic [7:0]        ctx_acc,
    output logic [7:0]        ctx_stat,
    output logic [7:0]        ctx_pgbyte,
    output logic              ctx_restore
);

    localparam int OFS_W = PC_W - PAGE_W;

    pc_op_e          op;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_nxt;
    logic [PC_W-1:0] stk_top;
    logic [PC_W-1:0] push_val;
    logic            push;
    logic            pop;

    pgpc_cmd_arb u_arb (
        .cmd_step (cmd_step),
        .cmd_jmp  (cmd_jmp),
        .cmd_call (cmd_call),
        .cmd_lda  (cmd_lda),
        .cmd_adda (cmd_adda),
        .cmd_tbl  (cmd_tbl),
        .cmd_irq  (cmd_irq),
        .cmd_ret  (cmd_ret),
        .cmd_reti (cmd_reti),
        .op       (op)
    );

    pgpc_next_addr #(
        .PC_W    (PC_W),
        .PAGE_W  (PAGE_W),
        .OFS_W   (OFS_W),
        .DATA_W  (DATA_W),
        .IRQ_VEC (IRQ_VEC)
    ) u_next (
        .op       (op),
        .pc       (pc_q),
        .stk_top  (stk_top),
        .page_sel (page_sel),
        .imm      (imm),
        .acc      (acc_in),
        .pc_nxt   (pc_nxt),
        .push     (push),
        .pop      (pop),
        .push_val (push_val)
    );

    pgpc_ret_stack #(
        .W     (PC_W),
        .DEPTH (STK_DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (push_val),
        .top   (stk_top)
    );

    pgpc_ctx_shadow #(
        .DATA_W (DATA_W)
    ) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .save      (op == OP_IRQ),
        .restore   (op == OP_RETI),
        .acc_in    (acc_in),
        .stat_in   (stat_in),
        .pgbyte_in (pgbyte_in),
        .acc_q     (ctx_acc),
        .stat_q    (ctx_stat),
        .pgbyte_q  (ctx_pgbyte),
        .restore_q (ctx_restore)
    );

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    assign pc_out = pc_q;

endmodule

// File: rtl/pgpc_chk.sv
// Module: pgpc_chk
// Property checker for pgpc_top, attached by bind. It observes the ports only.
module pgpc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_step,
    input logic        cmd_jmp,
    input logic        cmd_call,
    input logic        cmd_lda,
    input logic        cmd_adda,
    input logic        cmd_tbl,
    input logic        cmd_irq,
    input logic        cmd_ret,
    input logic        cmd_reti,
    input logic [9:0]  imm,
    input logic [7:0]  acc_in,
    input logic [1:0]  page_sel,
    input logic [11:0] pc_out,
    input logic        ctx_restore
);

    logic above_call, above_jmp, above_lda, above_adda, above_tbl, above_step, any_cmd;

    // Masks telling whether a higher-priority strobe is active.
    always_comb begin
        above_call = cmd_irq | cmd_reti | cmd_ret;
        above_jmp  = above_call | cmd_call;
        above_lda  = above_jmp | cmd_jmp;
        above_adda = above_lda | cmd_lda;
        above_tbl  = above_adda | cmd_adda;
        above_step = above_tbl | cmd_tbl;
        any_cmd    = above_step | cmd_step;
    end

    assert_reset_pc_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_out == 12'h000 && !ctx_restore));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_step && !above_step) |=> pc_out == $past(pc_out) + 12'd1);

    assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_jmp && !above_lda) |=> pc_out == {$past(page_sel), $past(imm)});

    assert_call_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_call && !above_call) |=> pc_out == {$past(page_sel), $past(imm)});

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lda && !above_lda) |=> (pc_out[9:8] == 2'b00 && pc_out[7:0] == $past(acc_in)
                                     && pc_out[11:10] == $past(page_sel)));

    assert_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_adda && !above_adda) |=> (pc_out[9:8] == 2'b00
                                       && pc_out[11:10] == $past(page_sel)
                                       && pc_out[7:0] == 8'($past(pc_out[7:0]) + $past(acc_in))));

    assert_tbl_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_tbl && !above_tbl) |=> pc_out[11:8] == $past(pc_out[11:8]));

    assert_irq_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq |=> pc_out == 12'h008);

    assert_restore_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reti && !cmd_irq) |=> ctx_restore);

    assert_restore_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_reti && !cmd_irq) |=> !ctx_restore);

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !any_cmd |=> $stable(pc_out));

endmodule

bind pgpc_top pgpc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_step    (cmd_step),
    .cmd_jmp     (cmd_jmp),
    .cmd_call    (cmd_call),
    .cmd_lda     (cmd_lda),
    .cmd_adda    (cmd_adda),
    .cmd_tbl     (cmd_tbl),
    .cmd_irq     (cmd_irq),
    .cmd_ret     (cmd_ret),
    .cmd_reti    (cmd_reti),
    .imm         (imm),
    .acc_in      (acc_in),
    .page_sel    (page_sel),
    .pc_out      (pc_out),
    .ctx_restore (ctx_restore)
);

// File: tb/sim_pgpc_top.sv
// Bench for pgpc_top: directed corners plus seeded random commands,
// compared against a behavioural reference kept in bench variables.
module sim_pgpc_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_step, cmd_jmp, cmd_call, cmd_lda, cmd_adda, cmd_tbl;
    logic        cmd_irq, cmd_ret, cmd_reti;
    logic [9:0]  imm;
    logic [7:0]  acc_in, stat_in, pgbyte_in;
    logic [1:0]  page_sel;
    logic [11:0] pc_out;
    logic [7:0]  ctx_acc, ctx_stat, ctx_pgbyte;
    logic        ctx_restore;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state.
    logic [11:0] m_pc;
    logic [11:0] m_ring [8];
    int          m_ptr;
    logic [7:0]  m_acc, m_stat, m_pg;
    logic        m_rst;

    // Strobe bit positions used by the bench.
    localparam int B_STEP = 0, B_JMP = 1, B_CALL = 2, B_LDA = 3, B_ADDA = 4,
                   B_TBL = 5, B_IRQ = 6, B_RET = 7, B_RETI = 8;

    always #4 clk = ~clk;

    pgpc_top u0 (
        .clk (clk), .rst_n (rst_n),
        .cmd_step (cmd_step), .cmd_jmp (cmd_jmp), .cmd_call (cmd_call),
        .cmd_lda (cmd_lda), .cmd_adda (cmd_adda), .cmd_tbl (cmd_tbl),
        .cmd_irq (cmd_irq), .cmd_ret (cmd_ret), .cmd_reti (cmd_reti),
        .imm (imm), .acc_in (acc_in), .page_sel (page_sel),
        .stat_in (stat_in), .pgbyte_in (pgbyte_in),
        .pc_out (pc_out), .ctx_acc (ctx_acc), .ctx_stat (ctx_stat),
        .ctx_pgbyte (ctx_pgbyte), .ctx_restore (ctx_restore)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Priority from the requirement list; returns the winning bit or -1.
    function automatic int winner(input logic [8:0] s);
        if (s[B_IRQ])  return B_IRQ;
        if (s[B_RETI]) return B_RETI;
        if (s[B_RET])  return B_RET;
        if (s[B_CALL]) return B_CALL;
        if (s[B_JMP])  return B_JMP;
        if (s[B_LDA])  return B_LDA;
        if (s[B_ADDA]) return B_ADDA;
        if (s[B_TBL])  return B_TBL;
        if (s[B_STEP]) return B_STEP;
        return -1;
    endfunction

    function automatic string tag_of(input int w, input logic [8:0] s);
        if ($countones(s) > 1) return "R12";
        case (w)
            B_STEP: return "R2";
            B_JMP:  return "R3";
            B_CALL: return "R4";
            B_LDA:  return "R5";
            B_ADDA: return "R6";
            B_TBL:  return "R7";
            B_IRQ:  return "R8";
            B_RET:  return "R9";
            B_RETI: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic mpush(input logic [11:0] v);
        m_ring[m_ptr] = v;
        m_ptr = (m_ptr + 1) % 8;
    endtask

    task automatic mpop(output logic [11:0] v);
        m_ptr = (m_ptr + 7) % 8;
        v = m_ring[m_ptr];
    endtask

    task automatic model_reset();
        m_pc = '0; m_ptr = 0; m_acc = '0; m_stat = '0; m_pg = '0; m_rst = 1'b0;
        for (int i = 0; i < 8; i++) m_ring[i] = '0;
    endtask

    task automatic clear_cmds();
        {cmd_reti, cmd_ret, cmd_irq, cmd_tbl, cmd_adda, cmd_lda, cmd_call, cmd_jmp, cmd_step} = '0;
    endtask

    // Drive one command set at a falling edge, update the model, check at the next falling edge.
    task automatic issue(input logic [8:0] s, input logic [9:0] im, input logic [7:0] a,
                         input logic [1:0] ps, input logic [7:0] st, input logic [7:0] pg,
                         input string force_tag);
        int w;
        string t;
        logic [11:0] v;
        {cmd_reti, cmd_ret, cmd_irq, cmd_tbl, cmd_adda, cmd_lda, cmd_call, cmd_jmp, cmd_step} = s;
        imm = im; acc_in = a; page_sel = ps; stat_in = st; pgbyte_in = pg;
        w = winner(s);
        t = (force_tag != "") ? force_tag : tag_of(w, s);
        m_rst = 1'b0;
        case (w)
            B_STEP: m_pc = m_pc + 12'd1;
            B_JMP:  m_pc = {ps, im};
            B_CALL: begin mpush(m_pc + 12'd1); m_pc = {ps, im}; end
            B_LDA:  m_pc = {ps, 2'b00, a};
            B_ADDA: m_pc = {ps, 2'b00, 8'(m_pc[7:0] + a)};
            B_TBL:  m_pc = {m_pc[11:8], 8'(m_pc[7:0] + a)};
            B_IRQ:  begin mpush(m_pc); m_pc = 12'h008; m_acc = a; m_stat = st; m_pg = pg; end
            B_RET:  begin mpop(v); m_pc = v; end
            B_RETI: begin mpop(v); m_pc = v; m_rst = 1'b1; end
            default: ;
        endcase
        @(negedge clk);
        chk({t, " pc"}, 32'(pc_out), 32'(m_pc));
        chk("R11 restore strobe", 32'(ctx_restore), 32'(m_rst));
        if (w == B_IRQ || w == B_RETI) begin
            chk("R8/R11 shadow acc", 32'(ctx_acc), 32'(m_acc));
            chk("R8/R11 shadow stat", 32'(ctx_stat), 32'(m_stat));
            chk("R8/R11 shadow page", 32'(ctx_pgbyte), 32'(m_pg));
        end
        clear_cmds();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        clear_cmds();
        repeat (3) @(negedge clk);
        model_reset();
        chk("R1 reset pc", 32'(pc_out), 32'h0);
        chk("R1 reset strobe", 32'(ctx_restore), 32'h0);
        chk("R1 reset shadow", 32'({ctx_acc, ctx_stat, ctx_pgbyte}), 32'h0);
        rst_n = 1'b1;
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [8:0] s;
        int r;
        imm = '0; acc_in = '0; page_sel = '0; stat_in = '0; pgbyte_in = '0;
        void'($urandom(32'd5150));
        @(negedge clk);
        do_reset();

        // R1: idle after reset, then a return with nothing pushed.
        issue(9'h000, 10'h0, 8'h00, 2'd0, 8'h0, 8'h0, "R1 idle");
        issue(9'h1 << B_RET, 10'h0, 8'h00, 2'd0, 8'h0, 8'h0, "R1 empty pop");

        // R2: wrap from the top of page 3.
        issue(9'h1 << B_JMP, 10'h3FF, 8'h00, 2'd3, 8'h0, 8'h0, "R3");
        issue(9'h1 << B_STEP, 10'h0, 8'h00, 2'd0, 8'h0, 8'h0, "R2 wrap");
        issue(9'h1 << B_JMP, 10'h3FF, 8'h00, 2'd0, 8'h0, 8'h0, "R3");
        issue(9'h1 << B_STEP, 10'h0, 8'h00, 2'd2, 8'h0, 8'h0, "R2 page cross");

        // R7: carry out of the low byte is dropped, bits 11..8 kept.
        issue(9'h1 << B_JMP, 10'h2F0, 8'h00, 2'd2, 8'h0, 8'h0, "R3");
        issue(9'h1 << B_TBL, 10'h0, 8'h20, 2'd1, 8'h0, 8'h0, "R7 carry");
        // R6 and R5 from an address with bits 9..8 set.
        issue(9'h1 << B_ADDA, 10'h0, 8'hFF, 2'd1, 8'h0, 8'h0, "R6 wrap");
        issue(9'h1 << B_JMP, 10'h3A0, 8'h00, 2'd0, 8'h0, 8'h0, "R3");
        issue(9'h1 << B_LDA, 10'h0, 8'h5C, 2'd3, 8'h0, 8'h0, "R5");

        // R10: nine calls then nine returns.
        for (int i = 0; i < 9; i++)
            issue(9'h1 << B_CALL, 10'(i * 37 + 5), 8'h0, 2'(i), 8'h0, 8'h0, "R4");
        for (int i = 0; i < 9; i++)
            issue(9'h1 << B_RET, 10'h0, 8'h0, 2'd0, 8'h0, 8'h0, "R10 ring pop");

        // R8 / R11: interrupt entry and return.
        issue(9'h1 << B_JMP, 10'h155, 8'h0, 2'd1, 8'h0, 8'h0, "R3");
        issue(9'h1 << B_IRQ, 10'h0, 8'hA5, 2'd2, 8'h3C, 8'hC3, "R8");
        issue(9'h1 << B_STEP, 10'h0, 8'h11, 2'd0, 8'h22, 8'h33, "R2");
        issue(9'h1 << B_RETI, 10'h0, 8'h44, 2'd0, 8'h55, 8'h66, "R9 reti");
        issue(9'h000, 10'h0, 8'h0, 2'd0, 8'h0, 8'h0, "R11 strobe drop");
        chk("R11 shadow held", 32'({ctx_acc, ctx_stat, ctx_pgbyte}), 32'h00A53CC3);

        // R12: colliding strobes.
        issue((9'h1 << B_IRQ) | (9'h1 << B_JMP), 10'h100, 8'h9, 2'd3, 8'h1, 8'h2, "R12 irq wins");
        issue((9'h1 << B_CALL) | (9'h1 << B_JMP) | (9'h1 << B_STEP), 10'h077, 8'h0, 2'd2, 8'h0, 8'h0, "R12 call wins");
        issue((9'h1 << B_RETI) | (9'h1 << B_RET), 10'h0, 8'h0, 2'd0, 8'h0, 8'h0, "R12 reti wins");

        // Seeded random mix.
        for (int k = 0; k < 600; k++) begin
            r = int'($urandom % 16);
            if (r < 9)       s = 9'h1 << r;
            else if (r < 13) s = 9'($urandom);
            else             s = 9'h000;
            issue(s, 10'($urandom), 8'($urandom), 2'($urandom), 8'($urandom), 8'($urandom), "");
        end

        // Reset in mid-run clears everything again.
        do_reset();
        issue(9'h1 << B_RET, 10'h0, 8'h0, 2'd0, 8'h0, 8'h0, "R1 empty after reset");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule